// File: doc/BRIEF.md
# Linear Burst Controller for a DDR Pseudo-Static RAM Link

This block runs one complete linear burst transaction at a time against an external pseudo-static RAM that uses an 8-bit double-data-rate bus, an active-low chip select, a single-ended clock and a bidirectional read/write data strobe. A client raises a request with a row number and a direction bit. The block forms the 48-bit command/address word and shifts it out a byte per clock phase. For writes it counts a fixed number of latency phases and then pulls the client's bytes. For reads it runs the clock until the device raises the strobe, captures the fixed-length burst and hands each byte to the client with its position in the burst.

The block has one system clock. Each active cycle is one phase of the device clock, so every device-clock edge carries one byte. Burst length, latency, row width and the row-to-address shift are parameters. A generate option selects whether a read starts on a strobe edge or on a strobe level.

Top module: `hbus_burst_ctrl`

## Requirements
- R1: After reset and whenever no transaction is in progress, `hb_cs_n_o` is 1, `hb_ck_o` is 0, `hb_dq_oe_o`, `hb_rwds_oe_o`, `busy_o`, `done_o` and `rd_valid_o` are 0.
- R2: A request taken while idle drives `busy_o` high and `hb_cs_n_o` low from the next cycle. A request raised while busy is ignored, and no further chip-select cycle follows the current transaction.
- R3: The first 6 chip-select-low cycles drive the command/address word on `hb_dq_o` with `hb_dq_oe_o` high, bits 47..40 first. Bit 47 is 1 for a read and 0 for a write. Bit 46 is 0 and bit 45 is 1. Bits 44..16 hold the row shifted left by 7, truncated to 29 bits, and bits 15..0 are zero.
- R4: While chip select is low, `hb_ck_o` is 0 in the first cycle and inverts every cycle after that. Whenever chip select is high, `hb_ck_o` is 0.
- R5: On a write, exactly 27 cycles pass between the last command byte and the first data cycle. In these cycles neither `hb_dq_oe_o` nor `hb_rwds_oe_o` is asserted.
- R6: On a write, `wr_ready_o` is high for 640 consecutive cycles. In each of them `hb_dq_o` equals `wr_data_i` of that same cycle, `hb_dq_oe_o` is 1, and the strobe is driven (`hb_rwds_oe_o` = 1) low (`hb_rwds_o` = 0).
- R7: On a read, `hb_dq_oe_o` stays 0 after the command phase. The clock keeps inverting, and no byte is delivered until the cycle in which `hb_rwds_i` is first seen high after being low.
- R8: If the strobe rise is seen at clock edge T, the `hb_dq_i` value sampled at edge T+k (k = 1..640) appears on `rd_data_o` with `rd_index_o` = k-1 and `rd_valid_o` = 1 in the cycle after edge T+k.
- R9: In the cycle after the last data byte, `hb_cs_n_o` is 1, `hb_ck_o` is 0, and both the data bus and the strobe are released.
- R10: `done_o` is high for exactly one cycle, the cycle after chip select rises. `busy_o` falls in the cycle after that.
- R11: A write holds chip select low for exactly 6 + 27 + 640 cycles. Every burst moves exactly 640 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one cycle per device-clock phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a transaction (taken only while idle) |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| req_row_i | input | ROW_W | Row number placed into the address field |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| wr_data_i | input | 8 | Write byte, consumed in every `wr_ready_o` cycle |
| wr_ready_o | output | 1 | This cycle consumes `wr_data_i` |
| rd_valid_o | output | 1 | `rd_data_o` holds a captured byte |
| rd_data_o | output | 8 | Captured read byte |
| rd_index_o | output | IDX_W | Position of the byte in the burst |
| hb_cs_n_o | output | 1 | Device chip select, active low |
| hb_ck_o | output | 1 | Device clock |
| hb_dq_o | output | 8 | Data bus out value |
| hb_dq_oe_o | output | 1 | Data bus output enable |
| hb_dq_i | input | 8 | Data bus in value |
| hb_rwds_o | output | 1 | Strobe out value (write mask, always 0) |
| hb_rwds_oe_o | output | 1 | Strobe output enable |
| hb_rwds_i | input | 1 | Strobe in value |

## Verification
The sequencer's state register sits behind every bus output. Chip select and the command byte change in the cycle after the request edge, and write data is combinational within its `wr_ready_o` cycle. A read byte needs two edges: one to see the strobe rise and one to capture. It then appears one cycle after capture. The bench drives and samples at the falling edge only. It counts the chip-select-low cycles from the first one, so the latency gap lands at cycle index 33 for writes. For reads, it drives pattern byte k on the k-th falling edge after the one where it raised the strobe, and it expects index k at the falling edge after that. End-of-burst, done and idle are each checked on the three falling edges that follow the last chip-select-low cycle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_LAT,
      ST_WDAT,
      ST_RWAIT,
      ST_RDAT,
      ST_FIN,
      ST_DONE
   } hb_state_e;

   localparam int CA_BYTES = 6;
   localparam int CA_BITS  = 48;
   localparam int ADDR_HI_W = 29;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hbus_ca_word.sv
module hbus_ca_word
   import hbus_pkg::*;
#(
   parameter int ROW_W     = 16,
   parameter int ROW_SHIFT = 7
) (
   input  logic             is_read,
   input  logic [ROW_W-1:0] row,
   input  logic [2:0]       byte_sel,
   output logic [7:0]       ca_byte
);

   localparam int WIDE_W = ROW_W + ROW_SHIFT;

   logic [WIDE_W-1:0]    row_wide;
   logic [ADDR_HI_W-1:0] addr_hi;
   logic [CA_BITS-1:0]   ca;
   int unsigned          lane;

   assign row_wide = {row, {ROW_SHIFT{1'b0}}};

   generate
      if (WIDE_W >= ADDR_HI_W) begin : g_trunc
         assign addr_hi = row_wide[ADDR_HI_W-1:0];
      end else begin : g_pad
         assign addr_hi = {{(ADDR_HI_W-WIDE_W){1'b0}}, row_wide};
      end
   endgenerate

   // read flag, memory space (0), linear burst (1), upper address, zero low half
   assign ca = {is_read, 1'b0, 1'b1, addr_hi, 16'h0000};

   always_comb begin
      lane    = (byte_sel < 3'(CA_BYTES)) ? (CA_BYTES - 1 - int'(byte_sel)) : 0;
      ca_byte = ca[lane*8 +: 8];
   end

endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
   import hbus_pkg::*;
#(
   parameter int BURST_LEN = 640,
   parameter int LAT_EDGES = 27,
   parameter int CNT_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             dir_write,
   input  logic             rd_start,
   output hb_state_e        state_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ck_o,
   output logic             active_o
);

   hb_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ck_q;

   always_comb begin
      active_o = (state_q == ST_CMD)  || (state_q == ST_LAT) ||
                 (state_q == ST_WDAT) || (state_q == ST_RWAIT) ||
                 (state_q == ST_RDAT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (req) state_q <= ST_CMD;
            end
            ST_CMD: begin
               if (cnt_q == CNT_W'(CA_BYTES - 1)) begin
                  cnt_q   <= '0;
                  state_q <= dir_write ? ST_LAT : ST_RWAIT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_LAT: begin
               if (cnt_q == CNT_W'(LAT_EDGES - 1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_WDAT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WDAT, ST_RDAT: begin
               if (cnt_q == CNT_W'(BURST_LEN - 1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_FIN;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RWAIT: begin
               cnt_q <= '0;
               if (rd_start) state_q <= ST_RDAT;
            end
            ST_FIN:  state_q <= ST_DONE;
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ck_q <= 1'b0;
      else if (active_o) ck_q <= ~ck_q;
      else               ck_q <= 1'b0;
   end

   assign state_o = state_q;
   assign cnt_o   = cnt_q;
   assign ck_o    = ck_q;

endmodule

// File: rtl/hbus_rd_capture.sv
module hbus_rd_capture #(
   parameter int CNT_W         = 10,
   parameter int IDX_W         = 10,
   parameter bit START_ON_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             capturing,
   input  logic [CNT_W-1:0] idx,
   input  logic [7:0]       dq_in,
   input  logic             rwds_in,
   output logic             start,
   output logic             valid_o,
   output logic [7:0]       data_o,
   output logic [IDX_W-1:0] index_o
);

   logic rwds_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rwds_q <= 1'b0;
      else        rwds_q <= rwds_in;
   end

   generate
      if (START_ON_EDGE) begin : g_edge
         assign start = armed & rwds_in & ~rwds_q;
      end else begin : g_level
         assign start = armed & rwds_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         index_o <= '0;
      end else begin
         valid_o <= capturing;
         if (capturing) begin
            data_o  <= dq_in;
            index_o <= idx[IDX_W-1:0];
         end
      end
   end

endmodule

// File: rtl/hbus_burst_ctrl.sv
module hbus_burst_ctrl
   import hbus_pkg::*;
#(
   parameter int ROW_W         = 16,
   parameter int ROW_SHIFT     = 7,
   parameter int BURST_LEN     = 640,
   parameter int LAT_EDGES     = 27,
   parameter bit START_ON_EDGE = 1'b1,
   localparam int IDX_W        = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             req_write_i,
   input  logic [ROW_W-1:0] req_row_i,
   output logic             busy_o,
   output logic             done_o,
   input  logic [7:0]       wr_data_i,
   output logic             wr_ready_o,
   output logic             rd_valid_o,
   output logic [7:0]       rd_data_o,
   output logic [IDX_W-1:0] rd_index_o,
   output logic             hb_cs_n_o,
   output logic             hb_ck_o,
   output logic [7:0]       hb_dq_o,
   output logic             hb_dq_oe_o,
   input  logic [7:0]       hb_dq_i,
   output logic             hb_rwds_o,
   output logic             hb_rwds_oe_o,
   input  logic             hb_rwds_i
);

   localparam int MAXC  = max3(BURST_LEN, LAT_EDGES, CA_BYTES);
   localparam int CNT_W = (IDX_W > $clog2(MAXC)) ? IDX_W : $clog2(MAXC);

   generate
      if (BURST_LEN < 2) begin : g_bad_len
         $error("BURST_LEN must be at least 2");
      end
      if (LAT_EDGES < 1) begin : g_bad_lat
         $error("LAT_EDGES must be at least 1");
      end
      if (ROW_W < 1 || ROW_W + ROW_SHIFT > ADDR_HI_W) begin : g_bad_row
         $error("ROW_W + ROW_SHIFT must fit the 29-bit address field");
      end
   endgenerate

   hb_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic             ck_q;
   logic             active;
   logic             rd_start;
   logic             wr_q;
   logic [ROW_W-1:0] row_q;
   logic [7:0]       ca_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= 1'b0;
         row_q <= '0;
      end else if (state == ST_IDLE && req_i) begin
         wr_q  <= req_write_i;
         row_q <= req_row_i;
      end
   end

   hbus_seq #(
      .BURST_LEN (BURST_LEN),
      .LAT_EDGES (LAT_EDGES),
      .CNT_W     (CNT_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_i),
      .dir_write (wr_q),
      .rd_start  (rd_start),
      .state_o   (state),
      .cnt_o     (cnt),
      .ck_o      (ck_q),
      .active_o  (active)
   );

   hbus_ca_word #(
      .ROW_W     (ROW_W),
      .ROW_SHIFT (ROW_SHIFT)
   ) i_ca (
      .is_read  (~wr_q),
      .row      (row_q),
      .byte_sel (cnt[2:0]),
      .ca_byte  (ca_byte)
   );

   hbus_rd_capture #(
      .CNT_W         (CNT_W),
      .IDX_W         (IDX_W),
      .START_ON_EDGE (START_ON_EDGE)
   ) i_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (state == ST_RWAIT),
      .capturing (state == ST_RDAT),
      .idx       (cnt),
      .dq_in     (hb_dq_i),
      .rwds_in   (hb_rwds_i),
      .start     (rd_start),
      .valid_o   (rd_valid_o),
      .data_o    (rd_data_o),
      .index_o   (rd_index_o)
   );

   assign hb_cs_n_o    = ~active;
   assign hb_ck_o      = ck_q & active;
   assign hb_dq_oe_o   = (state == ST_CMD) || (state == ST_WDAT);
   assign hb_rwds_oe_o = (state == ST_WDAT);
   assign hb_rwds_o    = 1'b0;
   assign wr_ready_o   = (state == ST_WDAT);
   assign busy_o       = (state != ST_IDLE);
   assign done_o       = (state == ST_DONE);

   always_comb begin
      hb_dq_o = 8'h00;
      if (state == ST_CMD)       hb_dq_o = ca_byte;
      else if (state == ST_WDAT) hb_dq_o = wr_data_i;
   end

endmodule

// File: rtl/hbus_burst_chk.sv
module hbus_burst_chk #(
   parameter int IDX_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             wr_ready_o,
   input logic             rd_valid_o,
   input logic [IDX_W-1:0] rd_index_o,
   input logic             hb_cs_n_o,
   input logic             hb_ck_o,
   input logic             hb_dq_oe_o,
   input logic             hb_rwds_o,
   input logic             hb_rwds_oe_o
);

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (hb_cs_n_o && !hb_ck_o && !hb_dq_oe_o && !hb_rwds_oe_o));

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !busy_o) |=> (busy_o && !hb_cs_n_o));

   // R4
   ck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hb_cs_n_o && !$past(hb_cs_n_o)) |-> (hb_ck_o != $past(hb_ck_o)));

   // R4
   ck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_cs_n_o |-> !hb_ck_o);

   // R6
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready_o |-> (!hb_cs_n_o && hb_dq_oe_o && hb_rwds_oe_o && !hb_rwds_o));

   // R7
   rd_no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !$past(hb_dq_oe_o));

   // R8
   rd_index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && $past(rd_valid_o)) |-> (rd_index_o == IDX_W'($past(rd_index_o) + 1'b1)));

   // R9
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_cs_n_o |-> (!hb_dq_oe_o && !hb_rwds_oe_o));

   // R10
   done_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (hb_cs_n_o && $past(hb_cs_n_o) && !$past(hb_cs_n_o, 2)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

endmodule

bind hbus_burst_ctrl hbus_burst_chk #(.IDX_W(IDX_W)) i_burst_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .wr_ready_o   (wr_ready_o),
   .rd_valid_o   (rd_valid_o),
   .rd_index_o   (rd_index_o),
   .hb_cs_n_o    (hb_cs_n_o),
   .hb_ck_o      (hb_ck_o),
   .hb_dq_oe_o   (hb_dq_oe_o),
   .hb_rwds_o    (hb_rwds_o),
   .hb_rwds_oe_o (hb_rwds_oe_o)
);

// File: tb/test_hbus_burst_ctrl.sv
`timescale 1ns/1ps
module test_hbus_burst_ctrl;

   localparam int ROW_W = 16;
   localparam int IDX_W = 10;
   localparam int NBYTE = 640;
   localparam int NLAT  = 27;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_i = 1'b0;
   logic             req_write_i = 1'b0;
   logic [ROW_W-1:0] req_row_i = '0;
   logic             busy_o, done_o;
   logic [7:0]       wr_data_i = '0;
   logic             wr_ready_o;
   logic             rd_valid_o;
   logic [7:0]       rd_data_o;
   logic [IDX_W-1:0] rd_index_o;
   logic             hb_cs_n_o, hb_ck_o, hb_dq_oe_o, hb_rwds_o, hb_rwds_oe_o;
   logic [7:0]       hb_dq_o;
   logic [7:0]       hb_dq_i = '0;
   logic             hb_rwds_i = 1'b0;

   int  total = 0;
   int  bad   = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   hbus_burst_ctrl i_hbus_burst_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_write_i(req_write_i),
      .req_row_i(req_row_i), .busy_o(busy_o), .done_o(done_o),
      .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o), .rd_valid_o(rd_valid_o),
      .rd_data_o(rd_data_o), .rd_index_o(rd_index_o), .hb_cs_n_o(hb_cs_n_o),
      .hb_ck_o(hb_ck_o), .hb_dq_o(hb_dq_o), .hb_dq_oe_o(hb_dq_oe_o),
      .hb_dq_i(hb_dq_i), .hb_rwds_o(hb_rwds_o), .hb_rwds_oe_o(hb_rwds_oe_o),
      .hb_rwds_i(hb_rwds_i)
   );

   // {write, row[15:0], seed[7:0], strobe delay[7:0]}
   localparam logic [32:0] VEC [6] = '{
      {1'b1, 16'h0000, 8'h11, 8'd0},
      {1'b0, 16'h0000, 8'h22, 8'd3},
      {1'b1, 16'hFFFF, 8'hA5, 8'd0},
      {1'b0, 16'hFFFF, 8'h5A, 8'd0},
      {1'b0, 16'h1234, 8'h7E, 8'd20},
      {1'b1, 16'h0155, 8'hC3, 8'd0}
   };

   function automatic logic [7:0] pat(input logic [7:0] s, input int k);
      return 8'(int'(s) + k * 5 + (k >> 8) * 59);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic run_txn(input bit wr, input logic [15:0] row,
                          input logic [7:0] seed, input int delay, input bit poke);
      logic [28:0] ahi;
      logic [47:0] ca;
      int  cyc = 0, pre = -1, nbytes = 0, nvalid = 0, dq_k = 0;
      int  bad_ca = 0, bad_ck = 0, bad_dat = 0, bad_bus = 0, early = 0;
      bit  rwds_up = 1'b0, poke_hold = 1'b0;
      logic prev_ck = 1'b0;

      ahi = 29'({16'h0, row} << 7);
      ca  = {~wr, 1'b0, 1'b1, ahi, 16'h0000};

      @(negedge clk);
      req_i = 1'b1; req_write_i = wr; req_row_i = row;
      @(negedge clk);
      req_i = 1'b0;
      // R2: accepted on the request edge
      chk(!hb_cs_n_o && busy_o, "R2", "cs low and busy after request", {hb_cs_n_o, busy_o}, 2'b01);

      forever begin
         if (poke_hold) begin req_i = 1'b0; poke_hold = 1'b0; end
         if (rd_valid_o) begin
            if (rd_data_o !== pat(seed, nvalid) || rd_index_o !== IDX_W'(nvalid)) bad_dat++;
            nvalid++;
         end
         if (hb_cs_n_o) break;
         if (cyc == 0 && hb_ck_o !== 1'b0) bad_ck++;
         if (cyc > 0 && hb_ck_o === prev_ck) bad_ck++;
         prev_ck = hb_ck_o;
         if (cyc < 6) begin
            if (hb_dq_oe_o !== 1'b1 || hb_dq_o !== ca[8*(5-cyc) +: 8]) bad_ca++;
         end else if (wr) begin
            if (wr_ready_o) begin
               if (nbytes == 0) pre = cyc;
               wr_data_i = pat(seed, nbytes);
               #1;
               if (hb_dq_o !== pat(seed, nbytes) || !hb_dq_oe_o || !hb_rwds_oe_o || hb_rwds_o)
                  bad_dat++;
               nbytes++;
               if (poke && nbytes == 100) begin req_i = 1'b1; poke_hold = 1'b1; end
            end else if (nbytes == 0 && (hb_dq_oe_o || hb_rwds_oe_o)) begin
               bad_bus++;
            end
         end else begin
            if (hb_dq_oe_o) bad_bus++;
            if (!rwds_up) begin
               if (rd_valid_o) early++;
               if (cyc - 6 == delay) begin hb_rwds_i = 1'b1; rwds_up = 1'b1; end
            end else begin
               hb_dq_i = pat(seed, dq_k);
               dq_k++;
            end
         end
         @(negedge clk);
         cyc++;
      end

      // R3
      chk(bad_ca == 0, "R3", "command/address byte mismatches", bad_ca, 0);
      // R4
      chk(bad_ck == 0, "R4", "clock phase errors while selected", bad_ck, 0);
      if (wr) begin
         // R5
         chk(pre == 6 + NLAT && bad_bus == 0, "R5", "first data cycle index", pre, 6 + NLAT);
         // R6
         chk(bad_dat == 0, "R6", "write byte mismatches", bad_dat, 0);
         // R11
         chk(nbytes == NBYTE && cyc == 6 + NLAT + NBYTE, "R11", "write bytes / selected cycles",
             (longint'(nbytes) << 16) | cyc, (longint'(NBYTE) << 16) | (6 + NLAT + NBYTE));
      end else begin
         // R7
         chk(early == 0 && bad_bus == 0, "R7", "early bytes or bus driven in read", early + bad_bus, 0);
         // R8
         chk(bad_dat == 0, "R8", "read byte/index mismatches", bad_dat, 0);
         // R11
         chk(nvalid == NBYTE, "R11", "read bytes delivered", nvalid, NBYTE);
      end
      // R9
      chk(hb_cs_n_o && !hb_ck_o && !hb_dq_oe_o && !hb_rwds_oe_o && !done_o, "R9",
          "end-of-burst lines {cs,ck,dqoe,rwdsoe,done}",
          {hb_cs_n_o, hb_ck_o, hb_dq_oe_o, hb_rwds_oe_o, done_o}, 5'b10000);
      hb_rwds_i = 1'b0; hb_dq_i = 8'h00;
      @(negedge clk);
      // R10
      chk(done_o && busy_o && hb_cs_n_o, "R10", "done one cycle after cs rise",
          {done_o, busy_o, hb_cs_n_o}, 3'b111);
      @(negedge clk);
      // R10 R1
      chk(!done_o && !busy_o && hb_cs_n_o && !rd_valid_o, "R10", "done cleared and idle",
          {done_o, busy_o, hb_cs_n_o, rd_valid_o}, 4'b0010);
      if (poke) begin
         int extra = 0;
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!hb_cs_n_o || busy_o) extra++;
         end
         // R2: request raised while busy left no trace
         chk(extra == 0, "R2", "cycles of activity after ignored request", extra, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(hb_cs_n_o && !hb_ck_o && !hb_dq_oe_o && !hb_rwds_oe_o && !busy_o && !done_o && !rd_valid_o,
          "R1", "reset state {cs,ck,dqoe,rwdsoe,busy,done,valid}",
          {hb_cs_n_o, hb_ck_o, hb_dq_oe_o, hb_rwds_oe_o, busy_o, done_o, rd_valid_o}, 7'b1000000);

      for (int v = 0; v < 6; v++) begin
         run_txn(VEC[v][32], VEC[v][31:16], VEC[v][15:8], int'(VEC[v][7:0]), 1'b0);
      end

      // directed: request while busy during a write
      run_txn(1'b1, 16'h0A0A, 8'h3C, 0, 1'b1);

      // directed: idle holds without a request
      repeat (5) @(negedge clk);
      // R1
      chk(hb_cs_n_o && !hb_ck_o && !busy_o, "R1", "idle hold {cs,ck,busy}",
          {hb_cs_n_o, hb_ck_o, busy_o}, 3'b100);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL R11 watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule